// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a memory-mapped watchdog. A 16-bit up-counter advances once per prescaled tick while the timer is enabled, and the tick rate comes from a 3-bit divider code. When the counter wraps from 0xFFFF to zero, the block drives a reset request pulse to the chip and sets a sticky overflow flag. Software services the watchdog by reloading the counter with 65536 minus the wanted number of ticks. Loading 0xFFFF while the timer runs forces a restart on the next tick.

Every software write must carry a protection key in the upper bits of the 32-bit word. The counter register uses one key and the two control registers use another. A write with a wrong key is dropped without any effect. An accepted write raises a write-in-progress flag for a fixed synchronisation delay.

Two reset inputs are provided. The power-on reset clears everything. The system reset, which the chip raises in answer to the reset request, clears everything except the overflow flag. Software can therefore find out after the restart that the watchdog caused it.

Top module: `keyed_wdt`

## Requirements
- R1: After power-on reset the counter (offset 0), control/status A (offset 4) and control B (offset 8) all read 0, and `wdt_rst_req` is low.
- R2: A write to offset 0 loads bits 15:0 into the counter only when bits 31:16 equal 0x5A5A. Any other key leaves the counter unchanged.
- R3: A write to offset 4 or offset 8 takes effect only when bits 31:8 equal 0xA5A5A5, and bits 7:0 form the payload. Offset 8 stores the payload byte and reads it back.
- R4: Control/status A reads as follows: bit 7 is enable, bit 5 is the read-only write-in-progress flag, bit 4 is the overflow flag, and bits 2:0 are the divider code. Bits 6 and 3 and bits 31:8 read 0.
- R5: Divider codes 0 to 7 select 1, 4, 16, 32, 64, 128, 1024 and 4096 clock cycles per tick. After the write edge that enables the timer, the counter first increments D edges later, where D is the selected divider, and then once every D edges.
- R6: Loading 65536-N and enabling the timer with divider 1 wraps the counter to 0 on the Nth edge. That edge sets the overflow flag, and `wdt_rst_req` is then high for PULSE_LEN cycles starting right after it. While the timer is disabled the counter holds, and no overflow occurs.
- R7: Loading 0xFFFF while the timer is enabled with divider 1 raises `wdt_rst_req` and the overflow flag on the very next edge.
- R8: The system reset clears the counter, enable, divider code and control B, but it keeps the overflow flag. The power-on reset also clears the overflow flag.
- R9: A keyed write to offset 4 with bit 4 at 0 clears the overflow flag, and bit 4 at 1 never sets it. If an overflow happens on the same edge as a clear, the flag ends up set.
- R10: Each accepted write raises the write-in-progress flag for exactly SYNC_CYCLES (2) cycles after the write edge. A write with a wrong key does not raise it.
- R11: The prescaler restarts from zero when the enable bit goes from 0 to 1 and when an accepted write changes the divider code.
- R12: If a counter load falls on the same edge as a tick that would wrap the counter, the load wins and no overflow occurs.
- R13: The counter can be read at offset 0 at any time, in bits 15:0, with bits 31:16 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| por_n | input | 1 | Active-low power-on reset, clears all state |
| sys_rst_n | input | 1 | Active-low system reset, keeps the overflow flag |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | 32 | Write word: key in the upper bits, payload in the lower bits |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_req | output | 1 | Reset request pulse raised on overflow |

## Verification
Two events can fall on the same edge: a counter wrap that sets the overflow flag, and a software write that clears it. The bench arranges this by loading 0xFFFF with divider 1 and issuing the clear on the next edge, then checks that the flag is still set. A second collision, a counter reload on the edge where a tick would wrap the counter, is set up one cycle after loading 0xFFFE. It is judged by an unchanged flag, a quiet reset request and the reloaded value on the counter.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 3;

  localparam logic [BUS_W-CNT_W-1:0]  CNT_KEY = 16'h5A5A;
  localparam logic [BUS_W-BYTE_W-1:0] CTL_KEY = 24'hA5A5A5;

  localparam int unsigned OFS_CNT  = 0;
  localparam int unsigned OFS_CSRA = 4;
  localparam int unsigned OFS_CSRB = 8;

  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned BUSY_BIT = 5;
  localparam int unsigned OVF_BIT  = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CNT,
    SEL_CSRA,
    SEL_CSRB
  } reg_sel_e;

  // clock cycles per tick for each divider code
  function automatic int unsigned div_of(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 16;
      3'd3:    return 32;
      3'd4:    return 64;
      3'd5:    return 128;
      3'd6:    return 1024;
      default: return 4096;
    endcase
  endfunction
endpackage

// File: rtl/keyed_wdt_prescaler.sv
module keyed_wdt_prescaler
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] code,
  input  logic             clr,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] lim;

  assign lim  = PRE_W'(div_of(code) - 1);
  assign tick = en && (pre_cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (!en || clr) begin
      pre_cnt <= '0;  // held at zero while stopped, restarted on code change
    end else if (pre_cnt == lim) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R5: with a divider above 1, no two ticks come back to back
  assert_tick_spacing_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && lim != '0) |=> !tick);

  // R11: a code change restarts the division from zero
  assert_restart_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_cnt == '0));
endmodule

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              ovf_flag,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              en,
  output logic [SEL_W-1:0]  cks,
  output logic              cnt_we,
  output logic [CNT_W-1:0]  cnt_wval,
  output logic              ovf_clr,
  output logic              pre_clr
);
  localparam int unsigned BUSY_W = $clog2(SYNC_CYCLES + 1);

  reg_sel_e          sel;
  logic              key_cnt_ok;
  logic              key_ctl_ok;
  logic              acc_cnt;
  logic              acc_csra;
  logic              acc_csrb;
  logic              acc_any;
  logic [BYTE_W-1:0] payload;
  logic [BYTE_W-1:0] csrb_q;
  logic [BYTE_W-1:0] csra_view;
  logic [BUSY_W-1:0] busy_cnt;
  logic              busy;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(OFS_CNT))       return SEL_CNT;
    else if (a == ADDR_W'(OFS_CSRA)) return SEL_CSRA;
    else if (a == ADDR_W'(OFS_CSRB)) return SEL_CSRB;
    else                             return SEL_NONE;
  endfunction

  assign sel        = decode(bus_addr);
  assign key_cnt_ok = (bus_wdata[BUS_W-1:CNT_W] == CNT_KEY);
  assign key_ctl_ok = (bus_wdata[BUS_W-1:BYTE_W] == CTL_KEY);
  assign payload    = bus_wdata[BYTE_W-1:0];

  assign acc_cnt  = bus_wr && (sel == SEL_CNT)  && key_cnt_ok;
  assign acc_csra = bus_wr && (sel == SEL_CSRA) && key_ctl_ok;
  assign acc_csrb = bus_wr && (sel == SEL_CSRB) && key_ctl_ok;
  assign acc_any  = acc_cnt || acc_csra || acc_csrb;

  assign cnt_we   = acc_cnt;
  assign cnt_wval = bus_wdata[CNT_W-1:0];
  assign ovf_clr  = acc_csra && !payload[OVF_BIT];
  assign pre_clr  = acc_csra && (payload[SEL_W-1:0] != cks);
  assign busy     = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      cks    <= '0;
      csrb_q <= '0;
    end else begin
      if (acc_csra) begin
        en  <= payload[EN_BIT];
        cks <= payload[SEL_W-1:0];
      end
      if (acc_csrb) begin
        csrb_q <= payload;
      end
    end
  end

  // write-in-progress countdown standing in for the domain crossing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (acc_any) begin
      busy_cnt <= BUSY_W'(SYNC_CYCLES);
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_comb begin
    csra_view              = '0;
    csra_view[EN_BIT]      = en;
    csra_view[BUSY_BIT]    = busy;
    csra_view[OVF_BIT]     = ovf_flag;
    csra_view[SEL_W-1:0]   = cks;
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CNT:  bus_rdata[CNT_W-1:0]  = cnt_val;
      SEL_CSRA: bus_rdata[BYTE_W-1:0] = csra_view;
      SEL_CSRB: bus_rdata[BYTE_W-1:0] = csrb_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R3: a control write with a wrong key leaves enable and divider as they were
  assert_keyless_ctl_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_CSRA && !key_ctl_ok) |=> ($stable(en) && $stable(cks)));

  // R10: every accepted write shows as in progress on the next cycle
  assert_busy_after_write_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    acc_any |=> busy);
endmodule

// File: rtl/keyed_wdt_counter.sv
module keyed_wdt_counter
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             tick,
  input  logic             we,
  input  logic [CNT_W-1:0] wval,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             rst_req
);
  localparam int unsigned PL_W = $clog2(PULSE_LEN + 1);

  logic ovf_evt;

  assign ovf_evt = tick && !we && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (we) begin
      cnt <= wval;  // a load beats a tick
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // sticky flag on the power-on reset only; set beats clear
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ovf <= 1'b0;
    end else if (ovf_evt) begin
      ovf <= 1'b1;
    end else if (rst_n && ovf_clr) begin
      ovf <= 1'b0;
    end
  end

  if (PULSE_LEN <= 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= ovf_evt;
    end
  end else begin : g_stretch
    logic [PL_W-1:0] pulse_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pulse_cnt <= '0;
      end else if (ovf_evt) begin
        pulse_cnt <= PL_W'(PULSE_LEN);
      end else if (pulse_cnt != '0) begin
        pulse_cnt <= pulse_cnt - 1'b1;
      end
    end
    assign rst_req = (pulse_cnt != '0);
  end

  // R6: a wrap raises the flag and the request and leaves the counter at zero
  assert_wrap_flags_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !we && (&cnt)) |=> (ovf && rst_req && cnt == '0));

  // R6: without a tick or a load the counter holds
  assert_hold_idle_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !we) |=> $stable(cnt));

  // R12: a load lands exactly, even against a tick
  assert_load_wins_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cnt == $past(wval)));

  // R8: the flag stays set until a clear or the power-on reset
  assert_ovf_sticky_R8 : assert property (@(posedge clk) disable iff (!por_n)
    (ovf && !(rst_n && ovf_clr)) |=> ovf);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_CYCLES = 2,
  parameter int unsigned PULSE_LEN   = 4,
  parameter int unsigned PRE_W       = 12
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_req
);
  logic             rst_n;
  logic             en;
  logic [SEL_W-1:0] cks;
  logic             cnt_we;
  logic [CNT_W-1:0] cnt_wval;
  logic             ovf_clr;
  logic             pre_clr;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             ovf;

  assign rst_n = por_n & sys_rst_n;

  keyed_wdt_regs #(
    .ADDR_W      (ADDR_W),
    .SYNC_CYCLES (SYNC_CYCLES)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt),
    .ovf_flag  (ovf),
    .bus_rdata (bus_rdata),
    .en        (en),
    .cks       (cks),
    .cnt_we    (cnt_we),
    .cnt_wval  (cnt_wval),
    .ovf_clr   (ovf_clr),
    .pre_clr   (pre_clr)
  );

  keyed_wdt_prescaler #(
    .PRE_W (PRE_W)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .code  (cks),
    .clr   (pre_clr),
    .tick  (tick)
  );

  keyed_wdt_counter #(
    .PULSE_LEN (PULSE_LEN)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .por_n   (por_n),
    .tick    (tick),
    .we      (cnt_we),
    .wval    (cnt_wval),
    .ovf_clr (ovf_clr),
    .cnt     (cnt),
    .ovf     (ovf),
    .rst_req (wdt_rst_req)
  );

  // R2: a counter write with a wrong key changes nothing when no tick is due
  assert_keyless_cnt_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_CNT) && bus_wdata[31:16] != 16'h5A5A && !tick)
      |=> $stable(cnt));
endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyed_wdt #(.PULSE_LEN(PULSE)) u_keyed_wdt (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wdt_rst_req (wdt_rst_req)
  );

  function automatic int bdiv(input int k);
    int t;
    t = (k < 3) ? (1 << (2 * k)) : (k < 6) ? (1 << (k + 2)) : (1 << (2 * k - 2));
    return t;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] c0;
    cyc(5);
    por_n = 1'b1;
    sys_rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    rd(0, v); chk("R1 cnt", v, 0);
    rd(4, v); chk("R1 csra", v, 0);
    rd(8, v); chk("R1 csrb", v, 0);
    chk("R1 req", {31'b0, wdt_rst_req}, 0);

    // R2 / R10 keyless counter writes
    wr(0, 32'h0000_1234);
    rd(4, v); chk("R10 no busy on keyless", v, 0);
    rd(0, v); chk("R2 no key", v, 0);
    wr(0, 32'h5A5B_1234);
    rd(0, v); chk("R2 bad key", v, 0);
    wr(0, 32'h5A5A_1234);
    rd(4, v); chk("R10 busy n0", v, 32'h20);
    rd(0, v); chk("R13 cnt read", v, 32'h0000_1234);
    cyc(1); rd(4, v); chk("R10 busy n1", v, 32'h20);
    cyc(1); rd(4, v); chk("R10 busy n2", v, 32'h00);

    // R3 control B and key gating
    wr(8, 32'hA5A5_A53C);
    rd(8, v); chk("R3 csrb keyed", v, 32'h3C);
    wr(8, 32'hA5A5_A4FF);
    rd(8, v); chk("R3 csrb bad key", v, 32'h3C);
    wr(8, 32'h5A5A_00FF);
    rd(8, v); chk("R3 csrb cnt key", v, 32'h3C);
    wr(4, 32'h0000_0087);
    cyc(5);
    rd(4, v); chk("R3 csra keyless", v, 0);
    rd(0, v); chk("R3 no count", v, 32'h1234);

    // R4 layout, R6 disabled hold
    wr(4, 32'hA5A5_A56B);
    cyc(2);
    rd(4, v); chk("R4 layout", v, 32'h03);
    cyc(20);
    rd(0, v); chk("R6 disabled hold", v, 32'h1234);

    // R5 sweep over all divider codes
    for (int k = 0; k < 8; k++) begin
      int d;
      d = bdiv(k);
      wr(0, 32'h5A5A_0000);
      wr(4, 32'hA5A5_A580 | k);
      cyc(d - 1); rd(0, v); chk($sformatf("R5 code%0d pre-first", k), v, 0);
      cyc(1);     rd(0, v); chk($sformatf("R5 code%0d first", k), v, 1);
      cyc(2 * d - 1); rd(0, v); chk($sformatf("R5 code%0d pre-third", k), v, 2);
      cyc(1);     rd(0, v); chk($sformatf("R5 code%0d third", k), v, 3);
      wr(4, 32'hA5A5_A500 | k);
    end

    // R6 timeout of 20 ticks
    wr(4, 32'hA5A5_A500);
    wr(0, 32'h5A5A_FFEC);
    wr(4, 32'hA5A5_A580);
    cyc(19);
    rd(0, v); chk("R6 pre-wrap cnt", v, 32'hFFFF);
    chk("R6 pre-wrap req", {31'b0, wdt_rst_req}, 0);
    rd(4, v); chk("R6 pre-wrap flag", v & 32'h10, 0);
    cyc(1);
    rd(0, v); chk("R6 wrap cnt", v, 0);
    chk("R6 wrap req", {31'b0, wdt_rst_req}, 1);
    rd(4, v); chk("R6 wrap csra", v, 32'h90);
    cyc(PULSE - 1); chk("R6 req last", {31'b0, wdt_rst_req}, 1);
    cyc(1);         chk("R6 req end", {31'b0, wdt_rst_req}, 0);

    // R9 clear and no set by software
    wr(4, 32'hA5A5_A580);
    cyc(2); rd(4, v); chk("R9 cleared", v, 32'h80);
    wr(4, 32'hA5A5_A590);
    cyc(2); rd(4, v); chk("R9 no sw set", v, 32'h80);

    // R7 immediate restart
    wr(0, 32'h5A5A_FFFF);
    chk("R7 n0 req", {31'b0, wdt_rst_req}, 0);
    cyc(1);
    chk("R7 n1 req", {31'b0, wdt_rst_req}, 1);
    rd(4, v); chk("R7 n1 flag", v & 32'h10, 32'h10);
    cyc(PULSE + 2);

    // R9 set beats clear on the same edge
    wr(4, 32'hA5A5_A580);
    cyc(2);
    wr(0, 32'h5A5A_FFFF);
    wr(4, 32'hA5A5_A580);
    rd(4, v); chk("R9 set wins", v & 32'h10, 32'h10);
    chk("R9 req", {31'b0, wdt_rst_req}, 1);
    cyc(PULSE + 2);

    // R12 load beats wrapping tick
    wr(4, 32'hA5A5_A580);
    cyc(2);
    wr(0, 32'h5A5A_FFFE);
    cyc(1);
    rd(0, v); chk("R12 at FFFF", v, 32'hFFFF);
    wr(0, 32'h5A5A_1234);
    rd(0, v); chk("R12 load wins", v, 32'h1234);
    chk("R12 no req", {31'b0, wdt_rst_req}, 0);
    rd(4, v); chk("R12 no flag", v & 32'h10, 0);
    cyc(1);
    rd(0, v); chk("R12 resumes", v, 32'h1235);

    // R8 system reset keeps the flag, power-on clears it
    wr(0, 32'h5A5A_FFFF);
    cyc(PULSE + 1);
    wr(8, 32'hA5A5_A555);
    sys_rst_n = 1'b0;
    cyc(2);
    sys_rst_n = 1'b1;
    cyc(1);
    rd(4, v); chk("R8 flag kept", v, 32'h10);
    rd(0, v); chk("R8 cnt cleared", v, 0);
    rd(8, v); chk("R8 csrb cleared", v, 0);
    chk("R8 req low", {31'b0, wdt_rst_req}, 0);
    por_n = 1'b0;
    cyc(2);
    por_n = 1'b1;
    cyc(1);
    rd(4, v); chk("R8 por clears flag", v, 0);

    // R11 restart on code change and on enable rise
    wr(0, 32'h5A5A_0000);
    wr(4, 32'hA5A5_A582);
    cyc(10);
    wr(4, 32'hA5A5_A581);
    rd(0, c0); chk("R11 no tick yet", c0, 0);
    cyc(3); rd(0, v); chk("R11 code change hold", v, c0);
    cyc(1); rd(0, v); chk("R11 code change tick", v, c0 + 1);
    cyc(2);
    wr(4, 32'hA5A5_A501);
    cyc(3);
    wr(4, 32'hA5A5_A581);
    rd(0, c0);
    cyc(3); rd(0, v); chk("R11 enable rise hold", v, c0);
    cyc(1); rd(0, v); chk("R11 enable rise tick", v, c0 + 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule